// File: doc/BRIEF.md
# Receive Cell Disposition and Routing

This block takes the classification of one received cell and the receive connection descriptor that goes with it. It then decides where the cell buffer goes: to the user receive path, back to the transmit scheduler for retransmission (loopback routing), or nowhere (discard). It also computes the connection field that is written into the buffer's packet header. For a cell that fails header or lookup checks, it says whether that cell is still accepted. An accepted bad cell takes its queue, offset and pool settings from the non-user data registers, and the LC pointer in its header is cleared.

A bad cell has an HEC error, a VP/VC value outside the configured range, or a resolved VC index of zero. Such a cell is kept only when two enables are both on: the reassembly bad-cell enable and the receive-queue bad-frame mode. These checks are made before routing is considered, so a bad cell is never routed. For a good cell, the most significant bit of the descriptor state field turns routing on. While routing is on, user data cells are routed and non-user cells go to the user. State bit 2 extends routing to non-user cells as well. In every header the block builds, the inbound CLP bit replaces the least significant bit of the connection field.

Each cell offered on the input handshake produces exactly one verdict. The verdict is held in an output register until it is taken.

Top module: `rxd_cell_disposer`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: A good cell whose state field bit 7 (routing enable) is clear goes to the user: `out_dest` = 2'b00. The header field is descriptor word 0 with bit 0 replaced by CLP. `out_src` = 0 (descriptor settings). `out_ptr_zero` = 0 and `out_full_cell` = 0.
- R3: A good user data cell (`is_user` = 1) with state bit 7 set goes to the scheduler: `out_dest` = 2'b01. The header field is descriptor word 1 with bit 0 replaced by CLP. `out_src` = 0, `out_ptr_zero` = 0 and `out_full_cell` = 0.
- R4: A good non-user cell (`is_user` = 0) with state bit 7 set and state bit 2 clear goes to the user, with the same header field as in R2.
- R5: A good non-user cell with state bits 7 and 2 both set is routed exactly as in R3.
- R6: Whenever `out_dest` is not discard, bit 0 of `out_hdr_conn` equals the CLP bit of that cell.
- R7: A bad cell (`bad_hec`, `vpvc_range_err` or `vc_index_zero` set) is accepted when both `bad_rx_en` and `bad_frame_mode` are set. It then has `out_dest` = 2'b00, `out_src` = 1 (non-user registers), `out_ptr_zero` = 1, `out_full_cell` = 1 (53-byte cell), and a header field of zero except bit 0 = CLP. It does this whatever the routing bits are.
- R8: A bad cell for which either enable is clear is discarded: `out_dest` = 2'b10, with an all-zero header field and all flags zero.
- R9: `in_ready` = !`out_valid` || `out_ready`. An accepted cell's verdict appears on the outputs in the cycle after acceptance. The verdict stays unchanged while `out_valid` is high and `out_ready` is low. Each accepted cell yields exactly one verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Cell status and descriptor are presented |
| in_ready | output | 1 | Block can take a cell this cycle |
| bad_hec | input | 1 | Header error check failed |
| vpvc_range_err | input | 1 | VP/VC outside configured range |
| vc_index_zero | input | 1 | Looked-up VC index is zero |
| is_user | input | 1 | Cell carries user data (1) or non-user data (0) |
| clp | input | 1 | Cell loss priority bit of the inbound cell |
| lc_state | input | STATE_W | Descriptor state field; bit 7 routing enable, bit 2 non-user routing |
| desc_w0 | input | DESC_W | Descriptor word 0 (normal receive header value) |
| desc_w1 | input | DESC_W | Descriptor word 1 (routed header value) |
| bad_rx_en | input | 1 | Reassembly bad-cell receive enable |
| bad_frame_mode | input | 1 | Receive-queue bad-frame mode |
| out_valid | output | 1 | A verdict is held on the outputs |
| out_ready | input | 1 | Consumer takes the verdict |
| out_dest | output | 2 | 00 user, 01 scheduler, 10 discard |
| out_hdr_conn | output | DESC_W | Packet header connection field |
| out_src | output | 1 | 0 descriptor settings, 1 non-user data registers |
| out_ptr_zero | output | 1 | Clear the LC pointer in the header |
| out_full_cell | output | 1 | Store as a 53-byte cell |

## Verification
The assertions assume that the input fields stay constant from the moment `in_valid` is raised until the cell is taken. The CLP check compares against the input value at the accepting edge. The assertions also assume that `out_ready` is a plain level from a consumer and does not depend on `out_valid` in the same cycle. The bench changes inputs only at falling edges and keeps every cell's fields steady until it sees `in_ready` high. It drives `out_ready` from a fixed repeating pattern, which produces both stalls and back-to-back transfers.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    typedef enum logic [1:0] {
        DEST_USER  = 2'b00,
        DEST_SCHED = 2'b01,
        DEST_DROP  = 2'b10
    } dest_e;

    typedef enum logic {
        SRC_DESC    = 1'b0,
        SRC_NONUSER = 1'b1
    } src_e;

    typedef struct packed {
        dest_e dest;
        src_e  src;
        logic  ptr_zero;
        logic  full_cell;
    } verdict_t;

endpackage

// File: rtl/rxd_fault_screen.sv
module rxd_fault_screen (
    input  logic bad_hec,
    input  logic vpvc_range_err,
    input  logic vc_index_zero,
    input  logic bad_rx_en,
    input  logic bad_frame_mode,
    output logic is_bad,
    output logic keep_bad
);
    always_comb begin
        is_bad   = bad_hec | vpvc_range_err | vc_index_zero;
        keep_bad = is_bad & bad_rx_en & bad_frame_mode;
    end

    // R7/R8: a kept cell must be a bad cell
    always_comb begin
        a_r7_keep_only_bad: assert (!keep_bad || is_bad);
    end
endmodule

// File: rtl/rxd_route_pick.sv
module rxd_route_pick
    import rxd_pkg::*;
#(
    parameter int DESC_W      = 32,
    parameter int STATE_W     = 8,
    parameter int NONUSER_BIT = 2
) (
    input  logic               is_bad,
    input  logic               keep_bad,
    input  logic               is_user,
    input  logic               clp,
    input  logic [STATE_W-1:0] lc_state,
    input  logic [DESC_W-1:0]  desc_w0,
    input  logic [DESC_W-1:0]  desc_w1,
    output verdict_t           verdict,
    output logic [DESC_W-1:0]  hdr_conn
);
    localparam int ROUTE_BIT = STATE_W - 1;
    localparam logic [DESC_W-1:0] LSB_ONE = DESC_W'(1);

    logic route_on;
    logic nonuser_on;
    logic take_route;
    logic [DESC_W-1:0] clp_vec;
    logic unused_state_bits;

    assign route_on          = lc_state[ROUTE_BIT];
    assign clp_vec           = {{(DESC_W-1){1'b0}}, clp};
    assign unused_state_bits = ^lc_state;

    generate
        if (NONUSER_BIT < ROUTE_BIT) begin : g_nonuser
            assign nonuser_on = lc_state[NONUSER_BIT];
        end else begin : g_no_nonuser
            assign nonuser_on = 1'b0;
        end
    endgenerate

    assign take_route = route_on & (is_user | nonuser_on);

    always_comb begin
        verdict  = '{dest: DEST_USER, src: SRC_DESC, ptr_zero: 1'b0, full_cell: 1'b0};
        hdr_conn = '0;
        if (is_bad) begin
            if (keep_bad) begin
                verdict  = '{dest: DEST_USER, src: SRC_NONUSER, ptr_zero: 1'b1, full_cell: 1'b1};
                hdr_conn = clp_vec;
            end else begin
                verdict.dest = DEST_DROP;
            end
        end else if (take_route) begin
            verdict.dest = DEST_SCHED;
            hdr_conn     = (desc_w1 & ~LSB_ONE) | clp_vec;
        end else begin
            hdr_conn     = (desc_w0 & ~LSB_ONE) | clp_vec;
        end
    end

    // R7: a bad cell never reaches the scheduler
    always_comb begin
        a_r7_bad_not_routed: assert (!is_bad || verdict.dest != DEST_SCHED);
    end
endmodule

// File: rtl/rxd_cell_disposer.sv
module rxd_cell_disposer
    import rxd_pkg::*;
#(
    parameter int DESC_W      = 32,
    parameter int STATE_W     = 8,
    parameter int NONUSER_BIT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               bad_hec,
    input  logic               vpvc_range_err,
    input  logic               vc_index_zero,
    input  logic               is_user,
    input  logic               clp,
    input  logic [STATE_W-1:0] lc_state,
    input  logic [DESC_W-1:0]  desc_w0,
    input  logic [DESC_W-1:0]  desc_w1,
    input  logic               bad_rx_en,
    input  logic               bad_frame_mode,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [1:0]         out_dest,
    output logic [DESC_W-1:0]  out_hdr_conn,
    output logic               out_src,
    output logic               out_ptr_zero,
    output logic               out_full_cell
);
    typedef struct packed {
        logic              valid;
        verdict_t          verdict;
        logic [DESC_W-1:0] hdr;
    } hold_t;

    localparam hold_t HOLD_RESET = '{valid: 1'b0,
        verdict: '{dest: DEST_USER, src: SRC_DESC, ptr_zero: 1'b0, full_cell: 1'b0},
        hdr: '0};

    hold_t hold_d, hold_q;
    logic is_bad, keep_bad;
    verdict_t verdict_now;
    logic [DESC_W-1:0] hdr_now;
    logic take_in;

    rxd_fault_screen u_screen (
        .bad_hec        (bad_hec),
        .vpvc_range_err (vpvc_range_err),
        .vc_index_zero  (vc_index_zero),
        .bad_rx_en      (bad_rx_en),
        .bad_frame_mode (bad_frame_mode),
        .is_bad         (is_bad),
        .keep_bad       (keep_bad)
    );

    rxd_route_pick #(
        .DESC_W      (DESC_W),
        .STATE_W     (STATE_W),
        .NONUSER_BIT (NONUSER_BIT)
    ) u_pick (
        .is_bad   (is_bad),
        .keep_bad (keep_bad),
        .is_user  (is_user),
        .clp      (clp),
        .lc_state (lc_state),
        .desc_w0  (desc_w0),
        .desc_w1  (desc_w1),
        .verdict  (verdict_now),
        .hdr_conn (hdr_now)
    );

    assign in_ready = !hold_q.valid || out_ready;
    assign take_in  = in_valid && in_ready;

    always_comb begin
        hold_d = hold_q;
        if (take_in) begin
            hold_d.valid   = 1'b1;
            hold_d.verdict = verdict_now;
            hold_d.hdr     = hdr_now;
        end else if (out_ready) begin
            hold_d.valid   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= HOLD_RESET;
        else        hold_q <= hold_d;
    end

    assign out_valid     = hold_q.valid;
    assign out_dest      = hold_q.verdict.dest;
    assign out_src       = hold_q.verdict.src;
    assign out_ptr_zero  = hold_q.verdict.ptr_zero;
    assign out_full_cell = hold_q.verdict.full_cell;
    assign out_hdr_conn  = hold_q.hdr;

    a_r9_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_dest)
            && $stable(out_hdr_conn) && $stable(out_src) && $stable(out_ptr_zero));

    a_r6_clp_in_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> (out_dest == DEST_DROP) || (out_hdr_conn[0] == $past(clp)));

    a_r8_drop_clean: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_dest == DEST_DROP |-> out_hdr_conn == '0 && !out_ptr_zero
            && !out_full_cell && !out_src);

    a_r7_zeroed_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ptr_zero |-> out_dest == DEST_USER && out_src && out_full_cell
            && out_hdr_conn[DESC_W-1:1] == '0);

    a_r3_sched_plain: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_dest == DEST_SCHED |-> !out_ptr_zero && !out_src && !out_full_cell);
endmodule

// File: tb/rxd_cell_disposer_test.sv
module rxd_cell_disposer_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int SW = 8;
    localparam int WATCHDOG = 20000;

    typedef logic [DW+4:0] exp_t; // {dest[2], src, ptr_zero, full_cell, hdr[DW]}

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready;
    logic bad_hec = 0, vpvc_range_err = 0, vc_index_zero = 0, is_user = 0, clp = 0;
    logic [SW-1:0] lc_state = '0;
    logic [DW-1:0] desc_w0 = '0, desc_w1 = '0;
    logic bad_rx_en = 0, bad_frame_mode = 0;
    logic out_valid, out_ready = 1'b0;
    logic [1:0] out_dest;
    logic [DW-1:0] out_hdr_conn;
    logic out_src, out_ptr_zero, out_full_cell;

    exp_t exp_q[$];
    int checks = 0, errors = 0, sent = 0, got = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxd_cell_disposer #(.DESC_W(DW), .STATE_W(SW), .NONUSER_BIT(2)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .bad_hec(bad_hec), .vpvc_range_err(vpvc_range_err), .vc_index_zero(vc_index_zero),
        .is_user(is_user), .clp(clp), .lc_state(lc_state), .desc_w0(desc_w0),
        .desc_w1(desc_w1), .bad_rx_en(bad_rx_en), .bad_frame_mode(bad_frame_mode),
        .out_valid(out_valid), .out_ready(out_ready), .out_dest(out_dest),
        .out_hdr_conn(out_hdr_conn), .out_src(out_src), .out_ptr_zero(out_ptr_zero),
        .out_full_cell(out_full_cell)
    );

    function automatic string req_of(exp_t e, logic user, logic [SW-1:0] st);
        if (e[DW+4:DW+3] == 2'b10) return "R8";
        if (e[DW+1]) return "R7";
        if (e[DW+4:DW+3] == 2'b01) return (user ? "R3" : "R5");
        if (st[SW-1] && !user) return "R4";
        return "R2";
    endfunction

    function automatic exp_t model(logic hec, logic rng, logic idx, logic ben, logic bfm,
                                   logic user, logic c, logic [SW-1:0] st,
                                   logic [DW-1:0] w0, logic [DW-1:0] w1);
        logic [DW-1:0] h;
        if (hec || rng || idx) begin
            if (ben && bfm) begin
                h = '0; h[0] = c;
                return {2'b00, 1'b1, 1'b1, 1'b1, h};
            end
            return {2'b10, 3'b000, {DW{1'b0}}};
        end
        if (st[7] && (user || st[2])) begin
            h = w1; h[0] = c;
            return {2'b01, 3'b000, h};
        end
        h = w0; h[0] = c;
        return {2'b00, 3'b000, h};
    endfunction

    string tag_q[$];

    task automatic send(logic hec, logic rng, logic idx, logic ben, logic bfm,
                        logic user, logic c, logic [SW-1:0] st,
                        logic [DW-1:0] w0, logic [DW-1:0] w1);
        bit acc = 0;
        exp_t e;
        bad_hec = hec; vpvc_range_err = rng; vc_index_zero = idx;
        bad_rx_en = ben; bad_frame_mode = bfm; is_user = user; clp = c;
        lc_state = st; desc_w0 = w0; desc_w1 = w1; in_valid = 1'b1;
        e = model(hec, rng, idx, ben, bfm, user, c, st, w0, w1);
        while (!acc) begin
            #(CLK_PERIOD/4);
            acc = in_ready;
            if (acc) begin
                exp_q.push_back(e);
                tag_q.push_back(req_of(e, user, st));
                sent++;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    // monitor / scoreboard
    initial begin
        int cyc = 0;
        exp_t e, act;
        string tag;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            cyc++;
            out_ready = ((cyc % 7) != 2) && ((cyc % 7) != 3);
            #1;
            checks++;
            if (in_ready !== (!out_valid || out_ready)) begin
                errors++;
                $display("FAIL R9 in_ready act=%b exp=%b", in_ready, !out_valid || out_ready);
            end
            if (out_valid && out_ready) begin
                act = {out_dest, out_src, out_ptr_zero, out_full_cell, out_hdr_conn};
                got++;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R9 extra verdict act=%h exp=none", act);
                end else begin
                    e = exp_q.pop_front();
                    tag = tag_q.pop_front();
                    if (act !== e) begin
                        errors++;
                        $display("FAIL %s verdict act=%h exp=%h", tag, act, e);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [SW-1:0] st;
        int n = 0;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset act=%b%b exp=01", out_valid, in_ready);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 4; k++)
            for (int en = 0; en < 4; en++)
                for (int u = 0; u < 2; u++)
                    for (int rt = 0; rt < 4; rt++)
                        for (int c = 0; c < 2; c++) begin
                            st = (8'h5B & ~8'h84) | (rt[1] ? 8'h80 : 8'h00) | (rt[0] ? 8'h04 : 8'h00);
                            n++;
                            send(k == 1, k == 2, k == 3, en[0], en[1], u[0], c[0], st,
                                 32'hA5C3_0000 ^ (n * 32'h0001_0F1F) ^ {31'b0, ~c[0]},
                                 32'h3C5A_FFFF ^ (n * 32'h0300_0107) ^ {31'b0, ~c[0]});
                            if ((n % 11) == 0) @(negedge clk);
                        end
        repeat (20) @(negedge clk);
        checks++;
        if (got != sent || exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9 verdict count act=%0d exp=%0d", got, sent);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule